// File: doc/BRIEF.md
# I2C Write-Completion Poller

This block sits on the master side of an I2C bus, next to a simple bit-level master engine. It finds out when a serial memory has finished its internally timed write. While that cycle runs, the memory does not answer anything on the bus. Once the host has closed a write transaction with a stop condition, it pulses `go`. The poller then probes the memory over and over. Each probe is a start condition, then a control byte made of the 7-bit device address with the direction bit cleared, then a sample of the acknowledge bit.

When the memory does not acknowledge, the write is still in progress. In that case the poller closes the bus with a stop, waits a fixed number of idle cycles and probes again. When the memory acknowledges, the write is finished. The poller raises a one-cycle `done`. Depending on `keep_bus`, it either leaves the bus open so the next transfer can follow with no stop, or closes it with a stop first. A limit on the number of probes ends a memory that never answers with a held `timeout` flag. The `tries` output reports how many probes the last run issued.

The engine is driven one command at a time. `cmd_valid` pulses for one cycle with an operation code, and the engine answers with an `eng_done` pulse. For an acknowledge sample, `eng_ack` is valid alongside that pulse.

Top module: `wrp_poller`

## Requirements
- R1: After reset `busy`, `done`, `timeout` and `cmd_valid` are 0 and `tries` is 0.
- R2: Each probe issues the command codes start (0), then send-byte (1) with `cmd_byte` = {`dev_addr`, 1'b0}, then ack-sample (2), in that order.
- R3: After an ack-sample that returns `eng_ack` = 0, the poller issues a stop command (code 3) before the next start command.
- R4: When a probe is acknowledged the run ends with `done` high for exactly one cycle, with `busy` already low in that cycle and `timeout` low.
- R5: With `keep_bus` = 1 no stop follows the acknowledged probe, so the last command of the run is the ack-sample. With `keep_bus` = 0 exactly one stop follows it, and that stop is the last command.
- R6: After `max_tries` unacknowledged probes (a limit of 0 is treated as 1), the poller issues a stop and ends with `timeout` held high until the next accepted `go`, with no `done` and no further probe.
- R7: `tries` is cleared by an accepted `go`, counts each start command of the run, and holds its final value while idle.
- R8: Between the completion of a stop that follows a refused probe and the next start command, at least GAP_CYC idle cycles pass (default 4).
- R9: At most one command is outstanding: `cmd_valid` is not asserted again until `eng_done` has answered the previous command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start a polling run (accepted while idle) |
| dev_addr | input | 7 | Device address placed in the control byte |
| max_tries | input | CNT_W | Maximum number of probes per run |
| keep_bus | input | 1 | 1: no stop after an acknowledged probe |
| cmd_valid | output | 1 | One-cycle command strobe to the engine |
| cmd_op | output | 2 | Command code: 0 start, 1 send byte, 2 ack sample, 3 stop |
| cmd_byte | output | 8 | Byte to send with a send-byte command |
| eng_done | input | 1 | Engine finished the current command |
| eng_ack | input | 1 | Acknowledge seen, valid with eng_done of an ack sample |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse: memory acknowledged |
| timeout | output | 1 | Held flag: probe limit reached without acknowledge |
| tries | output | CNT_W | Probes issued in the current or last run |

## Verification
A sequencer stuck in the wrong phase shows up at the engine port by the next command strobe. The code arrives out of order, a start comes with no stop in front of it, or a strobe appears while a command is still outstanding. A wrong attempt count or a wrong limit comparison shows up when the run ends. The reported `tries`, the number of stops, or the choice between `done` and `timeout` then differs from a memory model whose busy length is known. A gap timer that is too short is caught at the first retry, by the cycle distance from the stop completing to the next start.

// File: rtl/wrp_pkg.sv
package wrp_pkg;

   typedef enum logic [1:0] {
      WRP_START = 2'd0,
      WRP_SEND  = 2'd1,
      WRP_ACKQ  = 2'd2,
      WRP_STOP  = 2'd3
   } wrp_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_GAP   = 2'd3
   } wrp_state_e;

endpackage

// File: rtl/wrp_try_counter.sv
module wrp_try_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] count,
   output logic             at_limit
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (inc && count != CNT_MAX) begin
         count <= count + 1'b1;
      end
   end

   // a zero limit compares true after the first probe, so it acts as one
   assign at_limit = (count >= limit);

endmodule

// File: rtl/wrp_gap_timer.sv
module wrp_gap_timer #(
   parameter int GAP_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic ready
);

   generate
      if (GAP_CYC > 0) begin : g_timed
         localparam int GW = $clog2(GAP_CYC + 1);
         logic [GW-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (load) begin
               cnt <= GW'(GAP_CYC);
            end else if (cnt != '0) begin
               cnt <= cnt - 1'b1;
            end
         end

         assign ready = (cnt == '0);
      end else begin : g_none
         assign ready = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/wrp_poller.sv
module wrp_poller
   import wrp_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int ADDR_W  = 7,
   parameter int GAP_CYC = 4,
   localparam int BYTE_W = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] dev_addr,
   input  logic [CNT_W-1:0]  max_tries,
   input  logic              keep_bus,
   output logic              cmd_valid,
   output logic [1:0]        cmd_op,
   output logic [BYTE_W-1:0] cmd_byte,
   input  logic              eng_done,
   input  logic              eng_ack,
   output logic              busy,
   output logic              done,
   output logic              timeout,
   output logic [CNT_W-1:0]  tries
);

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt_w
         $error("wrp_poller: CNT_W must lie in 2..16");
      end
      if (ADDR_W < 1) begin : g_bad_addr_w
         $error("wrp_poller: ADDR_W must be positive");
      end
      if (GAP_CYC < 0) begin : g_bad_gap
         $error("wrp_poller: GAP_CYC must not be negative");
      end
   endgenerate

   wrp_state_e        state;
   wrp_op_e           op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  lim_q;
   logic              keep_q;
   logic              ok_q;
   logic              exh_q;
   logic              done_q;
   logic              to_q;

   logic              accept;
   logic              probe_inc;
   logic              gap_load;
   logic              gap_ready;
   logic              at_limit;

   assign accept    = (state == ST_IDLE) && go;
   assign probe_inc = (state == ST_ISSUE) && (op_q == WRP_START);
   assign gap_load  = (state == ST_WAIT) && eng_done && (op_q == WRP_STOP)
                      && !ok_q && !exh_q;

   wrp_try_counter #(.CNT_W(CNT_W)) u_tries (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (accept),
      .inc      (probe_inc),
      .limit    (lim_q),
      .count    (tries),
      .at_limit (at_limit)
   );

   wrp_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (gap_load),
      .ready (gap_ready)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         op_q   <= WRP_START;
         addr_q <= '0;
         lim_q  <= '0;
         keep_q <= 1'b0;
         ok_q   <= 1'b0;
         exh_q  <= 1'b0;
         done_q <= 1'b0;
         to_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (go) begin
                  addr_q <= dev_addr;
                  lim_q  <= max_tries;
                  keep_q <= keep_bus;
                  to_q   <= 1'b0;
                  ok_q   <= 1'b0;
                  exh_q  <= 1'b0;
                  op_q   <= WRP_START;
                  state  <= ST_ISSUE;
               end
            end
            ST_ISSUE: state <= ST_WAIT;
            ST_WAIT: begin
               if (eng_done) begin
                  case (op_q)
                     WRP_START: begin
                        op_q  <= WRP_SEND;
                        state <= ST_ISSUE;
                     end
                     WRP_SEND: begin
                        op_q  <= WRP_ACKQ;
                        state <= ST_ISSUE;
                     end
                     WRP_ACKQ: begin
                        ok_q  <= eng_ack;
                        exh_q <= at_limit;
                        if (eng_ack && keep_q) begin
                           done_q <= 1'b1;
                           state  <= ST_IDLE;
                        end else begin
                           op_q  <= WRP_STOP;
                           state <= ST_ISSUE;
                        end
                     end
                     default: begin
                        if (ok_q) begin
                           done_q <= 1'b1;
                           state  <= ST_IDLE;
                        end else if (exh_q) begin
                           to_q  <= 1'b1;
                           state <= ST_IDLE;
                        end else begin
                           op_q  <= WRP_START;
                           state <= ST_GAP;
                        end
                     end
                  endcase
               end
            end
            default: begin
               if (gap_ready) begin
                  state <= ST_ISSUE;
               end
            end
         endcase
      end
   end

   assign cmd_valid = (state == ST_ISSUE);
   assign cmd_op    = op_q;
   assign cmd_byte  = {addr_q, 1'b0};
   assign busy      = (state != ST_IDLE);
   assign done      = done_q;
   assign timeout   = to_q;

endmodule

// File: rtl/wrp_poller_chk.sv
module wrp_poller_chk
   import wrp_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              go,
   input logic [ADDR_W-1:0] dev_addr,
   input logic [CNT_W-1:0]  max_tries,
   input logic              cmd_valid,
   input logic [1:0]        cmd_op,
   input logic [ADDR_W:0]   cmd_byte,
   input logic              eng_done,
   input logic              busy,
   input logic              done,
   input logic              timeout,
   input logic [CNT_W-1:0]  tries
);

   logic       outstanding;
   logic [1:0] last_op;
   logic       run_started;
   logic [CNT_W-1:0] eff_lim;

   assign eff_lim = (max_tries == '0) ? CNT_W'(1) : max_tries;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         outstanding <= 1'b0;
         last_op     <= WRP_STOP;
         run_started <= 1'b0;
      end else begin
         if (cmd_valid) outstanding <= 1'b1;
         else if (eng_done) outstanding <= 1'b0;
         if (cmd_valid) last_op <= cmd_op;
         if (go && !busy) run_started <= 1'b0;
         else if (cmd_valid && cmd_op == WRP_START) run_started <= 1'b1;
      end
   end

   a_r9_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> !outstanding);

   a_r2_send_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == WRP_SEND) |-> (run_started && last_op == WRP_START));

   a_r2_ackq_after_send: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == WRP_ACKQ) |-> (last_op == WRP_SEND));

   a_r2_ctrl_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == WRP_SEND) |-> (cmd_byte == {dev_addr, 1'b0}));

   a_r3_stop_before_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == WRP_START && run_started) |-> (last_op == WRP_STOP));

   a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r4_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r6_done_excludes_timeout: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && timeout));

   a_r6_tries_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (tries <= eff_lim));

   a_r4_end_reported: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done || timeout));

endmodule

bind wrp_poller wrp_poller_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .go        (go),
   .dev_addr  (dev_addr),
   .max_tries (max_tries),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .cmd_byte  (cmd_byte),
   .eng_done  (eng_done),
   .busy      (busy),
   .done      (done),
   .timeout   (timeout),
   .tries     (tries)
);

// File: tb/wrp_poller_bench.sv
`timescale 1ns/1ps
module wrp_poller_bench;
   import wrp_pkg::*;

   localparam int CNT_W   = 8;
   localparam int GAP_CYC = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             go = 1'b0;
   logic [6:0]       dev_addr = '0;
   logic [CNT_W-1:0] max_tries = '0;
   logic             keep_bus = 1'b0;
   logic             cmd_valid;
   logic [1:0]       cmd_op;
   logic [7:0]       cmd_byte;
   logic             eng_done = 1'b0;
   logic             eng_ack = 1'b0;
   logic             busy, done, timeout;
   logic [CNT_W-1:0] tries;

   always #2 clk = ~clk;

   wrp_poller #(.CNT_W(CNT_W), .ADDR_W(7), .GAP_CYC(GAP_CYC)) u_wrp_poller (
      .clk(clk), .rst_n(rst_n), .go(go), .dev_addr(dev_addr),
      .max_tries(max_tries), .keep_bus(keep_bus), .cmd_valid(cmd_valid),
      .cmd_op(cmd_op), .cmd_byte(cmd_byte), .eng_done(eng_done),
      .eng_ack(eng_ack), .busy(busy), .done(done), .timeout(timeout),
      .tries(tries));

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   // engine and memory model state
   int busy_left = 0;
   int n_start = 0, n_stop = 0;
   int order_err = 0, byte_err = 0, gap_err = 0, overlap_err = 0;
   int last_op = 3;
   int stop_done_cyc = 0;
   bit run_has_start = 1'b0;
   bit last_stop_refused = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int eff_lim(input int l);
      return (l == 0) ? 1 : l;
   endfunction
   function automatic bit exp_ok(input int b, input int l);
      return b < eff_lim(l);
   endfunction
   function automatic int exp_tries(input int b, input int l);
      return exp_ok(b, l) ? b + 1 : eff_lim(l);
   endfunction
   function automatic int exp_stops(input int b, input int l, input bit k);
      return exp_ok(b, l) ? b + (k ? 0 : 1) : eff_lim(l);
   endfunction

   initial forever begin
      @(posedge clk);
      cyc++;
   end

   // engine model: answers one command at a time, the memory refuses busy_left probes
   initial begin
      int op;
      int lat;
      @(negedge clk);
      forever begin
         if (cmd_valid) begin
            op = int'(cmd_op);
            case (op)
               0: begin
                  if (run_has_start && last_op != 3) order_err++;
                  if (run_has_start && last_stop_refused &&
                      (cyc - stop_done_cyc) < GAP_CYC + 1) gap_err++;
                  run_has_start = 1'b1;
                  n_start++;
               end
               1: begin
                  if (last_op != 0) order_err++;
                  if (cmd_byte != {dev_addr, 1'b0}) byte_err++;
               end
               2: if (last_op != 1) order_err++;
               default: begin
                  if (last_op != 2) order_err++;
                  n_stop++;
               end
            endcase
            last_op = op;
            lat = int'($urandom % 3);
            for (int i = 0; i <= lat; i++) begin
               @(negedge clk);
               if (cmd_valid) overlap_err++;
            end
            eng_done = 1'b1;
            if (op == 2) begin
               eng_ack = (busy_left == 0);
               last_stop_refused = (busy_left != 0);
               if (busy_left > 0) busy_left--;
            end else begin
               eng_ack = $urandom % 2;
            end
            if (op == 3) stop_done_cyc = cyc;
            @(negedge clk);
            eng_done = 1'b0;
            eng_ack = 1'b0;
         end else begin
            @(negedge clk);
         end
      end
   end

   task automatic run(input int b, input int l, input bit k);
      int waited;
      bit ok;
      int held;
      busy_left = b;
      n_start = 0; n_stop = 0;
      order_err = 0; byte_err = 0; gap_err = 0; overlap_err = 0;
      run_has_start = 1'b0; last_stop_refused = 1'b0;
      dev_addr = 7'($urandom);
      max_tries = CNT_W'(l);
      keep_bus = k;
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      chk(timeout == 1'b0, "R6", "timeout cleared by go", int'(timeout), 0);
      chk(tries == '0, "R7", "tries cleared by go", int'(tries), 0);
      waited = 0;
      while (!(done || timeout) && waited < 4000) begin
         @(negedge clk);
         waited++;
      end
      ok = exp_ok(b, l);
      chk(waited < 4000, "R4", "run ended", waited, 0);
      chk(done == ok, "R4", "done on acknowledge", int'(done), int'(ok));
      chk(timeout == !ok, "R6", "timeout on limit", int'(timeout), int'(!ok));
      chk(busy == 1'b0, "R4", "idle at end", int'(busy), 0);
      chk(int'(tries) == exp_tries(b, l), "R7", "probe count", int'(tries), exp_tries(b, l));
      chk(n_start == exp_tries(b, l), "R2", "start commands", n_start, exp_tries(b, l));
      chk(n_stop == exp_stops(b, l, k), "R3", "stop commands", n_stop, exp_stops(b, l, k));
      if (ok)
         chk(last_op == (k ? 2 : 3), "R5", "last command", last_op, k ? 2 : 3);
      else
         chk(last_op == 3, "R6", "stop after final refusal", last_op, 3);
      chk(order_err == 0, "R2", "command order errors", order_err, 0);
      chk(byte_err == 0, "R2", "control byte errors", byte_err, 0);
      chk(gap_err == 0, "R8", "retry gap errors", gap_err, 0);
      chk(overlap_err == 0, "R9", "overlapping commands", overlap_err, 0);
      held = int'(tries);
      @(negedge clk);
      chk(done == 1'b0, "R4", "done is one cycle", int'(done), 0);
      repeat (3) @(negedge clk);
      chk(int'(tries) == held, "R7", "tries held while idle", int'(tries), held);
      chk(timeout == !ok, "R6", "timeout held while idle", int'(timeout), int'(!ok));
      chk(n_start == exp_tries(b, l), "R6", "no probe after end", n_start, exp_tries(b, l));
   endtask

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
      chk(done == 1'b0, "R1", "reset done", int'(done), 0);
      chk(timeout == 1'b0, "R1", "reset timeout", int'(timeout), 0);
      chk(cmd_valid == 1'b0, "R1", "reset cmd_valid", int'(cmd_valid), 0);
      chk(tries == '0, "R1", "reset tries", int'(tries), 0);
      rst_n = 1'b1;
      @(negedge clk);
      run(0, 4, 1'b0);   // immediate acknowledge, stop after it
      run(0, 4, 1'b1);   // immediate acknowledge, bus kept
      run(3, 4, 1'b1);   // acknowledged on the last allowed probe
      run(4, 4, 1'b0);   // refused exactly up to the limit
      run(2, 0, 1'b0);   // zero limit acts as one probe
      run(0, 0, 1'b1);
      run(9, 3, 1'b1);   // long write, short limit
      run(6, 10, 1'b0);
      for (int i = 0; i < 20; i++) begin
         run(int'($urandom % 7), int'($urandom % 9), 1'($urandom));
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule